// File: doc/BRIEF.md
# Periodic PC Sampler with Wrapping Event Counters

This block sits beside a processor core and turns its activity into a sparse trace stream. While sampling is enabled, it takes a snapshot of the program counter at a fixed cycle interval. It also keeps three small counters that advance on exception entries, sleep cycles and load/store stall cycles. A counter does not report its running count. It only reports the moment it wraps, and that report goes out as a packet and as a one-cycle trigger pulse for an attached debugger.

All packets leave through one valid/ready port that carries a 3-bit kind and a 32-bit payload. The port has a single output register. A packet that arrives while that register still holds an unaccepted packet is dropped. The next packet delivered after any loss is a marker, so the consumer knows the stream has a gap. Enables are loaded from a small write port.

Top module: `pcs_event_tracer`

## Requirements
- R1: While `rst_n` is low at a clock edge, `pkt_valid` and `ovf_trig` are low after that edge, and all counters and the pending-loss flag are cleared.
- R2: Writing `cfg_en` with `cfg_we` high loads the enables: bit 0 is PC sampling, bit 1 the exception counter, bit 2 the sleep counter and bit 3 the stall counter. While PC sampling stays enabled, a PC packet (kind 0) is loaded every 64 cycles, the first one 64 edges after the edge that enabled it. No PC packet is loaded while sampling is disabled.
- R3: The PC packet payload is the `pc_in` value captured at the most recent edge where `retire` was high. Changes of `pc_in` without `retire` do not affect it.
- R4: The interval count is held at zero while sampling is disabled, so each enable starts a fresh 64-cycle interval.
- R5: Each event counter is 8 bits wide and advances on its strobe while enabled. On the strobe that takes it from 255 to 0, an overflow packet is loaded: kind 1 for exception, 2 for sleep, 3 for stall. Its payload is the last retired PC.
- R6: A disabled counter ignores its strobe and keeps its value, and it resumes from that value when enabled again.
- R7: `ovf_trig` bit 0 (exception), bit 1 (sleep) or bit 2 (stall) is high for the one cycle after that counter's wrap edge, whether or not the packet was delivered.
- R8: While `pkt_valid` is high and `pkt_ready` is low, the packet kind and payload stay unchanged.
- R9: A packet produced while the output register holds an unaccepted packet is dropped, and the pending-loss flag is set.
- R10: When the output register is free and a loss is pending, a marker packet (kind 7, payload 0) is loaded instead of any new packet. A new packet in that same cycle counts as a further loss.
- R11: When several packets are produced in one cycle, exception beats sleep, sleep beats stall, and any overflow beats a PC sample. Only the winner is loaded, and the losers count as a loss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pc_in | input | 32 | Current program counter |
| retire | input | 1 | Instruction-retired strobe; captures `pc_in` |
| evt_exc | input | 1 | Exception-entry strobe |
| evt_sleep | input | 1 | Sleep-cycle strobe |
| evt_stall | input | 1 | Load/store stall strobe |
| cfg_we | input | 1 | Enable register write strobe |
| cfg_en | input | 4 | Enable bits (see R2) |
| pkt_valid | output | 1 | Output packet valid |
| pkt_ready | input | 1 | Consumer accepts packet |
| pkt_kind | output | 3 | Packet kind (0 PC, 1/2/3 overflow, 7 marker) |
| pkt_payload | output | 32 | Packet payload |
| ovf_trig | output | 3 | One-cycle counter wrap pulses |

## Verification
The assertions check on every cycle that a held packet stays stable under backpressure, that a pending loss turns into a marker as soon as the output frees, that no PC packet appears unless sampling was enabled, that trigger pulses only come from enabled counters, and that reset clears the outputs. Only the bench scenarios can show the exact 64-cycle spacing and its restart on re-enable, a wrap landing on the 256th strobe, a counter holding its count while disabled, and the ordering of winner, marker and later packets when sources collide or the consumer stalls.

// File: rtl/pcs_trace_pkg.sv
// Shared constants for the PC sampler / event tracer.
// Assumes a 32-bit program counter and a 3-bit packet kind field.
package pcs_trace_pkg;
    localparam int PAYLOAD_W = 32;
    localparam int KIND_W    = 3;

    localparam logic [KIND_W-1:0] KIND_PC   = 3'd0;
    localparam logic [KIND_W-1:0] KIND_EXC  = 3'd1;
    localparam logic [KIND_W-1:0] KIND_SLP  = 3'd2;
    localparam logic [KIND_W-1:0] KIND_STL  = 3'd3;
    localparam logic [KIND_W-1:0] KIND_MARK = 3'd7;
endpackage

// File: rtl/pcs_interval.sv
// Fixed-interval tick generator for PC sampling.
// Counts cycles while enabled and pulses tick on the last cycle of each
// interval. The count is held at zero while disabled, so an enable always
// starts a fresh interval. Assumes INTERVAL >= 2.
module pcs_interval #(
    parameter int INTERVAL = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int IW = $clog2(INTERVAL);
    localparam logic [IW-1:0] LAST = IW'(INTERVAL - 1);

    logic [IW-1:0] cnt_q;

    assign tick = en && (cnt_q == LAST);

    // Interval counter: zero while disabled, wraps at the interval end.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/pcs_evt_counter.sv
// Small wrapping event counter.
// Advances on each strobe while enabled and keeps its value while disabled.
// The wrap output is high in the cycle whose strobe takes the count from
// all-ones back to zero. Assumes strobes are single-cycle qualified events.
module pcs_evt_counter #(
    parameter int CNT_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic strobe,
    output logic wrap
);
    logic [CNT_W-1:0] cnt_q;

    assign wrap = en && strobe && (cnt_q == '1);

    // Event count: clears on reset, advances on enabled strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (en && strobe) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/pcs_pkt_arb.sv
// Packet arbiter and single-entry output register.
// Picks the lowest-indexed request each cycle, loads it when the output
// register is free, and records any loss in a pending flag. While a loss
// is pending, the next free slot carries a marker packet instead.
// Assumes every request carries the same payload word.
module pcs_pkt_arb
    import pcs_trace_pkg::*;
#(
    parameter int NSRC = 4,
    parameter int PW   = PAYLOAD_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NSRC-1:0]              req,
    input  logic [NSRC-1:0][KIND_W-1:0]  kind_tab,
    input  logic [PW-1:0]                payload,
    input  logic                         out_ready,
    output logic                         out_valid,
    output logic [KIND_W-1:0]            out_kind,
    output logic [PW-1:0]                out_payload,
    output logic                         drop_pend
);
    localparam int SW = (NSRC > 1) ? $clog2(NSRC) : 1;

    logic            vld_q;
    logic [KIND_W-1:0] kind_q;
    logic [PW-1:0]   pl_q;
    logic            drop_q;
    logic [SW-1:0]   sel;
    logic            any_req;
    logic            multi_req;
    logic            free;

    // Fixed-priority pick: the lowest index wins.
    always_comb begin
        sel = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (req[i]) begin
                sel = SW'(i);
            end
        end
    end

    assign any_req   = |req;
    assign multi_req = ($countones(req) > 1);
    assign free      = !vld_q || out_ready;

    // Output register and pending-loss flag update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            kind_q <= '0;
            pl_q   <= '0;
            drop_q <= 1'b0;
        end else if (free) begin
            if (drop_q) begin
                vld_q  <= 1'b1;
                kind_q <= KIND_MARK;
                pl_q   <= '0;
                drop_q <= any_req;
            end else if (any_req) begin
                vld_q  <= 1'b1;
                kind_q <= kind_tab[sel];
                pl_q   <= payload;
                drop_q <= multi_req;
            end else begin
                vld_q  <= 1'b0;
            end
        end else begin
            drop_q <= drop_q | any_req;
        end
    end

    assign out_valid   = vld_q;
    assign out_kind    = kind_q;
    assign out_payload = pl_q;
    assign drop_pend   = drop_q;
endmodule

// File: rtl/pcs_event_tracer.sv
// Top level: periodic PC sampler plus wrapping event counters feeding one
// valid/ready packet port. Holds the enable register and the last retired
// PC, instantiates one counter per event source, and drives a registered
// wrap-trigger vector. Assumes event strobes are synchronous to clk.
module pcs_event_tracer
    import pcs_trace_pkg::*;
#(
    parameter int INTERVAL = 64,
    parameter int CNT_W    = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [PAYLOAD_W-1:0]  pc_in,
    input  logic                  retire,
    input  logic                  evt_exc,
    input  logic                  evt_sleep,
    input  logic                  evt_stall,
    input  logic                  cfg_we,
    input  logic [3:0]            cfg_en,
    output logic                  pkt_valid,
    input  logic                  pkt_ready,
    output logic [KIND_W-1:0]     pkt_kind,
    output logic [PAYLOAD_W-1:0]  pkt_payload,
    output logic [2:0]            ovf_trig
);
    localparam int NEVT = 3;
    localparam int NSRC = NEVT + 1;

    logic [NEVT:0]                en_q;
    logic [PAYLOAD_W-1:0]         pc_hold_q;
    logic [NEVT-1:0]              evt_vec;
    logic [NEVT-1:0]              wrap_vec;
    logic [NEVT-1:0]              trig_q;
    logic                         pc_tick;
    logic [NSRC-1:0]              req;
    logic [NSRC-1:0][KIND_W-1:0]  kind_tab;
    logic                         drop_pend;

    // Enable register: bit 0 PC sampling, bits 1..3 event counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (cfg_we) begin
            en_q <= cfg_en;
        end
    end

    // Last retired PC, used as the payload of every sample and overflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_hold_q <= '0;
        end else if (retire) begin
            pc_hold_q <= pc_in;
        end
    end

    pcs_interval #(
        .INTERVAL (INTERVAL)
    ) u_interval (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en_q[0]),
        .tick  (pc_tick)
    );

    assign evt_vec = {evt_stall, evt_sleep, evt_exc};

    // One counter per event source; index order sets arbitration priority.
    for (genvar e = 0; e < NEVT; e++) begin : g_cnt
        pcs_evt_counter #(
            .CNT_W (CNT_W)
        ) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (en_q[e+1]),
            .strobe (evt_vec[e]),
            .wrap   (wrap_vec[e])
        );
        assign kind_tab[e] = KIND_W'(e + 1);
    end
    assign kind_tab[NEVT] = KIND_PC;

    assign req = {pc_tick, wrap_vec};

    // Wrap trigger pulses, aligned with the packet load edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_q <= '0;
        end else begin
            trig_q <= wrap_vec;
        end
    end
    assign ovf_trig = trig_q;

    pcs_pkt_arb #(
        .NSRC (NSRC),
        .PW   (PAYLOAD_W)
    ) u_arb (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (req),
        .kind_tab    (kind_tab),
        .payload     (pc_hold_q),
        .out_ready   (pkt_ready),
        .out_valid   (pkt_valid),
        .out_kind    (pkt_kind),
        .out_payload (pkt_payload),
        .drop_pend   (drop_pend)
    );
endmodule

// File: rtl/pcs_event_tracer_chk.sv
// Protocol and ordering checker for pcs_event_tracer, attached by bind.
// Observes the packet port, the trigger vector, the enable register and
// the pending-loss flag.
module pcs_event_tracer_chk #(
    parameter int PW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pkt_valid,
    input logic          pkt_ready,
    input logic [2:0]    pkt_kind,
    input logic [PW-1:0] pkt_payload,
    input logic [2:0]    ovf_trig,
    input logic [3:0]    en_q,
    input logic          drop_pend
);
    // R1: reset leaves the packet port and triggers idle.
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (!pkt_valid && ovf_trig == 3'b000));

    // R8: a stalled packet is held unchanged.
    p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && !pkt_ready) |=>
            (pkt_valid && $stable(pkt_kind) && $stable(pkt_payload)));

    // R10: a pending loss yields a marker at the next free slot.
    p_marker_after_loss_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_pend && (!pkt_valid || pkt_ready)) |=>
            (pkt_valid && pkt_kind == 3'd7));

    // R2: a newly loaded PC packet needs sampling enabled.
    p_pc_needs_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && pkt_kind == 3'd0 && !$past(pkt_valid && !pkt_ready))
            |-> $past(en_q[0]));

    // R6: a trigger pulse only comes from an enabled counter.
    p_trig_needs_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_trig != 3'b000) |-> ((ovf_trig & ~$past(en_q[3:1])) == 3'b000));
endmodule

bind pcs_event_tracer pcs_event_tracer_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pkt_valid   (pkt_valid),
    .pkt_ready   (pkt_ready),
    .pkt_kind    (pkt_kind),
    .pkt_payload (pkt_payload),
    .ovf_trig    (ovf_trig),
    .en_q        (en_q),
    .drop_pend   (drop_pend)
);

// File: tb/tb_pcs_event_tracer.sv
module tb_pcs_event_tracer;
    timeunit 1ns;
    timeprecision 100ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pc_in = '0;
    logic        retire = 1'b0;
    logic        evt_exc = 1'b0;
    logic        evt_sleep = 1'b0;
    logic        evt_stall = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_en = '0;
    logic        pkt_valid;
    logic        pkt_ready = 1'b1;
    logic [2:0]  pkt_kind;
    logic [31:0] pkt_payload;
    logic [2:0]  ovf_trig;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    logic [31:0] last_pc = '0;

    typedef struct {
        int          at;
        logic [2:0]  kind;
        logic [31:0] pl;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    pcs_event_tracer dut (
        .clk (clk), .rst_n (rst_n), .pc_in (pc_in), .retire (retire),
        .evt_exc (evt_exc), .evt_sleep (evt_sleep), .evt_stall (evt_stall),
        .cfg_we (cfg_we), .cfg_en (cfg_en), .pkt_valid (pkt_valid),
        .pkt_ready (pkt_ready), .pkt_kind (pkt_kind),
        .pkt_payload (pkt_payload), .ovf_trig (ovf_trig)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, expv, cyc);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) tick();
    endtask

    task automatic push(input logic [2:0] k, input logic [31:0] p,
                        input int at, input string tag);
        exp_t e;
        e.at = at; e.kind = k; e.pl = p; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic cfg_write(input logic [3:0] v);
        cfg_we = 1'b1; cfg_en = v;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic do_retire(input logic [31:0] p);
        pc_in = p; retire = 1'b1;
        tick();
        retire = 1'b0;
        last_pc = p;
    endtask

    task automatic strobes(input logic [2:0] mask, input int n);
        for (int i = 0; i < n; i++) begin
            evt_exc = mask[0]; evt_sleep = mask[1]; evt_stall = mask[2];
            tick();
        end
        evt_exc = 1'b0; evt_sleep = 1'b0; evt_stall = 1'b0;
    endtask

    // Scoreboard monitor: pops one expected item per accepted packet.
    always @(negedge clk) begin
        if (rst_n && pkt_valid && pkt_ready) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R9 unexpected packet", {29'd0, pkt_kind}, 32'hFFFF_FFFF);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(pkt_kind == e.kind, {e.tag, " kind"}, {29'd0, pkt_kind}, {29'd0, e.kind});
                chk(pkt_payload == e.pl, {e.tag, " payload"}, pkt_payload, e.pl);
                if (e.at >= 0)
                    chk(cyc == e.at, {e.tag, " cycle"}, cyc, e.at);
            end
        end
    end

    initial begin
        #500000;
        chk(1'b0, "watchdog expired", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int n;
        // R1: reset state
        repeat (4) tick();
        @(negedge clk);
        chk(pkt_valid == 1'b0, "R1 valid in reset", pkt_valid, 0);
        chk(ovf_trig == 3'b000, "R1 trig in reset", ovf_trig, 0);
        tick();
        rst_n = 1'b1;
        tick();
        @(negedge clk);
        chk(pkt_valid == 1'b0, "R1 valid after reset", pkt_valid, 0);

        // R2/R3: periodic PC samples carry the last retired PC
        tick();
        do_retire(32'h1000_0040);
        n = cyc;
        push(3'd0, 32'h1000_0040, n + 65, "R2 first sample");
        cfg_write(4'b0001);
        wait_until(n + 80);
        do_retire(32'h2000_0080);
        pc_in = 32'hDEAD_BEEF;
        push(3'd0, 32'h2000_0080, n + 129, "R3 retired pc");
        wait_until(n + 140);
        cfg_write(4'b0000);

        // R4: disable mid-interval, re-enable restarts the interval
        wait_until(n + 200);
        n = cyc;
        cfg_write(4'b0001);
        wait_until(n + 30);
        cfg_write(4'b0000);
        wait_until(n + 40);
        n = cyc;
        push(3'd0, last_pc, n + 65, "R4 restart");
        cfg_write(4'b0001);
        wait_until(n + 70);
        cfg_write(4'b0000);
        wait_until(n + 200);

        // R5/R7/R11: exc and sleep wrap together; exc wins, marker follows
        cfg_write(4'b0110);
        n = cyc;
        push(3'd1, last_pc, n + 256, "R11 exc beats sleep");
        push(3'd7, 32'd0, n + 257, "R10 marker after loss");
        strobes(3'b011, 256);
        @(negedge clk);
        chk(ovf_trig == 3'b011, "R7 trig pulse", ovf_trig, 3'b011);
        tick();
        @(negedge clk);
        chk(ovf_trig == 3'b000, "R7 trig one cycle", ovf_trig, 0);
        tick();

        // R6: disabled counter ignores strobes and keeps its count
        strobes(3'b001, 100);
        cfg_write(4'b0100);
        strobes(3'b001, 300);
        cfg_write(4'b0010);
        n = cyc;
        push(3'd1, last_pc, n + 156, "R6 count held");
        strobes(3'b001, 156);
        repeat (10) tick();

        // R11: overflow beats a PC sample in the same cycle
        n = cyc;
        push(3'd0, last_pc, n + 65,  "R2 sample a");
        push(3'd0, last_pc, n + 129, "R2 sample b");
        push(3'd0, last_pc, n + 193, "R2 sample c");
        push(3'd1, last_pc, n + 257, "R11 overflow beats pc");
        push(3'd7, 32'd0,   n + 258, "R11 marker for dropped pc");
        push(3'd0, last_pc, n + 321, "R2 sample after collision");
        cfg_write(4'b0011);
        strobes(3'b001, 256);
        wait_until(n + 330);
        cfg_write(4'b0000);
        repeat (10) tick();

        // R8/R9/R10: backpressure, drop and marker
        pkt_ready = 1'b0;
        cfg_write(4'b1000);
        n = cyc;
        push(3'd3, last_pc, -1, "R8 held stall packet");
        strobes(3'b100, 256);
        @(negedge clk);
        chk(pkt_valid && pkt_kind == 3'd3, "R5 stall packet loaded", {29'd0, pkt_kind}, 3);
        strobes(3'b100, 256);
        @(negedge clk);
        chk(ovf_trig == 3'b100, "R7 trig despite drop", ovf_trig, 3'b100);
        chk(pkt_kind == 3'd3, "R9 held kind", {29'd0, pkt_kind}, 3);
        chk(pkt_payload == last_pc, "R8 held payload", pkt_payload, last_pc);
        tick();
        n = cyc;
        push(3'd7, 32'd0, n + 1, "R10 marker after backpressure");
        pkt_ready = 1'b1;
        repeat (5) tick();
        n = cyc;
        push(3'd3, last_pc, n + 256, "R10 no extra marker");
        strobes(3'b100, 256);
        repeat (100) tick();

        chk(exp_q.size() == 0, "R9 all expected packets seen", exp_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule